// File: doc/BRIEF.md
# Keyboard Scan Column Drive Selector

This block turns one firmware-written control byte into the drive-low enables of the column lines in a keyboard scan matrix. The byte has three fields. A 5-bit select code names one of 18 lines. An enable bit lets the block drive the matrix at all. A mode bit picks what gets pulled low: either the named line alone, or every line except the named one. The second mode helps firmware detect ghost keys.

Each line is modelled as open drain. Its enable bit at 1 means the pad pulls the line low. At 0 the line is released, and an external pull-up holds it high. Firmware writes the byte through a simple write strobe and can read it back at any time.

The enables sit in flip-flops and are computed from the byte being written. All 18 lines therefore settle together on the same clock edge that stores the write.

Top module: `kbd_col_driver`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x00 and every bit of `drv_low` is 0.
- R2: A clock edge with `wr_en` high stores `wr_data[6:0]` in the control byte. From then on `rd_data` returns the stored byte with the select code in bits 4..0, the enable in bit 5 and the mode in bit 6. Bit 7 always reads 0, whatever was written to it.
- R3: While the stored enable bit (bit 5) is 0, all 18 bits of `drv_low` are 0, whatever the select code and mode.
- R4: With enable 1, mode 0 and a select code k from 0 to 17, only `drv_low[k]` is 1. Code 0 names line 0 and code 17 names line 17.
- R5: With enable 1, mode 1 and a select code k from 0 to 17, every bit of `drv_low` is 1 except bit k.
- R6: With enable 1, mode 0 and a select code from 18 to 31, no line is driven, so `drv_low` is all zeros.
- R7: With enable 1, mode 1 and a select code from 18 to 31, all 18 lines are driven, so `drv_low` is all ones.
- R8: `drv_low` changes only on a clock edge that stores a write. It changes on that same edge, together with `rd_data`.
- R9: A clock edge with `wr_en` low leaves both `rd_data` and `drv_low` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to store: mode bit 6, enable bit 5, select code bits 4..0 |
| rd_data | output | 8 | Read-back of the stored control byte, with bit 7 at 0 |
| drv_low | output | 18 | Per-line enable: 1 pulls the column line low, 0 releases it |

## Verification
The assertions assume that reset is asserted on the first clock. They also assume that `wr_en` and `wr_data` are settled before each rising edge, so the previous-cycle write values that the properties sample are meaningful.

The bench drives every input on the falling edge and holds reset through the first rising edges. It then sweeps all 32 select codes under all four enable and mode combinations. These are followed by idle cycles, writes with bit 7 set, and a pseudo-random run of mixed writes and idles.

// File: rtl/kbd_drv_pkg.sv
package kbd_drv_pkg;

    localparam int SEL_W   = 5;
    localparam int DATA_W  = 8;
    localparam int LINES   = 18;
    localparam int CTRL_W  = SEL_W + 2;

    typedef struct packed {
        logic             invert;
        logic             enable;
        logic [SEL_W-1:0] sel;
    } drv_ctrl_t;

    function automatic drv_ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
        drv_ctrl_t c;
        c = drv_ctrl_t'(d[CTRL_W-1:0]);
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input drv_ctrl_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[CTRL_W-1:0] = c;
        return d;
    endfunction

endpackage

// File: rtl/kbd_ctrl_reg.sv
module kbd_ctrl_reg
    import kbd_drv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output drv_ctrl_t         ctrl_q,
    output drv_ctrl_t         ctrl_nxt
);

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr_en) begin
            ctrl_nxt = unpack_ctrl(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
        end
    end

endmodule

// File: rtl/kbd_line_decode.sv
module kbd_line_decode
    import kbd_drv_pkg::*;
#(
    parameter int NUM_LINES = LINES
) (
    input  drv_ctrl_t            ctrl,
    output logic [NUM_LINES-1:0] low_en
);

    // One comparator per line; codes at or above NUM_LINES match nothing,
    // so inverted mode then pulls every line low.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic hit;
        assign hit       = (ctrl.sel == SEL_W'(i));
        assign low_en[i] = ctrl.enable & (ctrl.invert ? ~hit : hit);
    end

endmodule

// File: rtl/kbd_drive_out.sv
module kbd_drive_out #(
    parameter int NUM_LINES = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] low_nxt,
    output logic [NUM_LINES-1:0] low_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
        end else begin
            low_q <= low_nxt;
        end
    end

endmodule

// File: rtl/kbd_col_driver.sv
module kbd_col_driver
    import kbd_drv_pkg::*;
#(
    parameter int NUM_LINES = LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_LINES-1:0] drv_low
);

    drv_ctrl_t              ctrl_q;
    drv_ctrl_t              ctrl_nxt;
    logic [NUM_LINES-1:0]   low_nxt;

    kbd_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ctrl_q   (ctrl_q),
        .ctrl_nxt (ctrl_nxt)
    );

    // Decode the next control value so the lines move on the write edge.
    kbd_line_decode #(.NUM_LINES(NUM_LINES)) u_dec (
        .ctrl   (ctrl_nxt),
        .low_en (low_nxt)
    );

    kbd_drive_out #(.NUM_LINES(NUM_LINES)) u_out (
        .clk     (clk),
        .rst     (rst),
        .low_nxt (low_nxt),
        .low_q   (drv_low)
    );

    assign rd_data = pack_ctrl(ctrl_q);

endmodule

// File: rtl/kbd_col_driver_chk.sv
module kbd_col_driver_chk #(
    parameter int NUM_LINES = 18
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [7:0]           wr_data,
    input logic [7:0]           rd_data,
    input logic [NUM_LINES-1:0] drv_low
);

    logic       en_b, inv_b, valid_b;
    assign en_b    = rd_data[5];
    assign inv_b   = rd_data[6];
    assign valid_b = (int'(rd_data[4:0]) < NUM_LINES);

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == 8'h00 && drv_low == '0));

    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> (rd_data == {1'b0, $past(wr_data[6:0])}));

    p_off_r3: assert property (@(posedge clk) disable iff (rst)
        !en_b |-> (drv_low == '0));

    p_single_r4: assert property (@(posedge clk) disable iff (rst)
        (en_b && !inv_b && valid_b) |-> ($countones(drv_low) == 1 && drv_low[rd_data[4:0]]));

    p_allbut_r5: assert property (@(posedge clk) disable iff (rst)
        (en_b && inv_b && valid_b) |-> ($countones(drv_low) == NUM_LINES - 1 && !drv_low[rd_data[4:0]]));

    p_badnone_r6: assert property (@(posedge clk) disable iff (rst)
        (en_b && !inv_b && !valid_b) |-> (drv_low == '0));

    p_badall_r7: assert property (@(posedge clk) disable iff (rst)
        (en_b && inv_b && !valid_b) |-> (drv_low == '1));

    p_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst)) |-> $stable(drv_low));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst)) |-> $stable(rd_data));

    p_bit7_r2: assert property (@(posedge clk) disable iff (rst) rd_data[7] == 1'b0);

endmodule

bind kbd_col_driver kbd_col_driver_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .drv_low (drv_low)
);

// File: tb/test_kbd_col_driver.sv
module test_kbd_col_driver;

    localparam int N = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_data = 8'h00;
    logic [7:0]   rd_data;
    logic [N-1:0] drv_low;

    int vectors = 0;
    int fails   = 0;
    int model_ctrl = 0;
    bit done = 0;

    always #10 clk = ~clk;

    kbd_col_driver i_kbd_col_driver (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .drv_low (drv_low)
    );

    function automatic logic [N-1:0] exp_drive(input int c);
        logic [N-1:0] v;
        int sel;
        sel = c % 32;
        v = '0;
        if (((c >> 5) & 1) == 1) begin
            for (int i = 0; i < N; i++) begin
                if (((c >> 6) & 1) == 1) v[i] = (i != sel);
                else                     v[i] = (i == sel);
            end
        end
        return v;
    endfunction

    function automatic string drive_tag(input int c);
        if (((c >> 5) & 1) == 0) return "R3";
        if ((c % 32) >= N) return (((c >> 6) & 1) == 1) ? "R7" : "R6";
        return (((c >> 6) & 1) == 1) ? "R5" : "R4";
    endfunction

    task automatic compare(input string rtag, input string dtag);
        vectors++;
        if (rd_data !== 8'(model_ctrl)) begin
            fails++;
            $display("FAIL %s rd_data actual=%02h expected=%02h", rtag, rd_data, 8'(model_ctrl));
        end
        vectors++;
        if (drv_low !== exp_drive(model_ctrl)) begin
            fails++;
            $display("FAIL %s drv_low actual=%05h expected=%05h", dtag, drv_low, exp_drive(model_ctrl));
        end
    endtask

    // Inputs change at the falling edge, outputs are checked one falling edge later.
    task automatic step(input bit we, input logic [7:0] d);
        bit prev_drive_same;
        wr_en   = we;
        wr_data = d;
        @(posedge clk);
        prev_drive_same = 1;
        if (we) model_ctrl = int'(d & 8'h7F);
        @(negedge clk);
        if (we) compare("R2", drive_tag(model_ctrl));
        else    compare("R9", "R8");
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int lfsr;
        @(negedge clk);
        @(negedge clk);
        model_ctrl = 0;
        compare("R1", "R1");
        rst = 1'b0;

        // R3..R7: full sweep of codes under every enable/mode pair
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 32; s++) begin
                step(1'b1, 8'((m << 5) | s));
            end
        end

        // R9 / R8: idle cycles with changing data must not disturb anything
        step(1'b1, 8'h25);
        for (int k = 0; k < 6; k++) step(1'b0, 8'(k * 37));
        step(1'b1, 8'h73);
        for (int k = 0; k < 4; k++) step(1'b0, 8'h00);

        // R2: bit 7 is never stored
        step(1'b1, 8'hFF);
        step(1'b1, 8'hA0);
        step(1'b1, 8'h80);

        // boundaries of the valid code range, R4 and R5
        step(1'b1, 8'h20);
        step(1'b1, 8'h31);
        step(1'b1, 8'h32);
        step(1'b1, 8'h71);
        step(1'b1, 8'h72);
        step(1'b1, 8'h60);

        // mixed pseudo-random traffic
        lfsr = 32'h1ACE;
        for (int k = 0; k < 400; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            step(((lfsr >> 3) & 3) != 0, 8'(lfsr >> 4));
        end

        // R1: reset in the middle of operation clears everything
        step(1'b1, 8'h7F);
        rst = 1'b1;
        @(posedge clk);
        model_ctrl = 0;
        @(negedge clk);
        compare("R1", "R1");
        rst = 1'b0;
        step(1'b0, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule